// File: doc/BRIEF.md
# Low-Bit Banked Register File

This block is a 128-entry register file with 64-bit entries. It holds its entries in eight memory banks, and each bank can do one read and one write per cycle. A register goes to the bank given by the three low bits of its 7-bit number. Its word inside that bank is given by the four high bits. Consecutive register numbers therefore land in different banks. A group of FMA lanes and other functional units can then reach the file in the same cycle without any multiported storage.

Every cycle, several read requesters and several write requesters each present a register number. The block works out which requests each bank can serve. It returns a combinational grant per requester in the same cycle. A requester that is not granted has stalled and must present its request again. Reads and writes are arbitrated separately, and both use a fixed priority in which the lowest-numbered requester wins. Each bank has a read enable and a write enable, and these are raised only for accesses that are granted. An untouched bank therefore sees no enable and can be clock gated. Read data for a granted request appears on that requester's data lane one cycle after the grant. Register 0 always reads as zero. A write to register 0 is accepted and then dropped, and neither one takes a bank slot.

Top module: `lowbit_bank_rf`

## Requirements
- R1: A nonzero register number n maps to bank n[2:0] and to word n[6:3] inside that bank. Requests that target different banks are all granted in the same cycle.
- R2: A read granted in cycle N places its value on that requester's 64-bit lane of rd_data in cycle N+1. When the requester was not granted in cycle N, or it read register 0, the lane is zero in cycle N+1.
- R3: A grant bit is never high unless the matching request bit is high in the same cycle.
- R4: When two or more reads with nonzero register numbers target the same bank, only the lowest-indexed of those requesters is granted in that cycle. The others see a low grant bit, and their lanes are zero in the next cycle.
- R5: Write conflicts in a bank are resolved apart from reads, using the same lowest-index-wins rule. A write that loses leaves the register file unchanged.
- R6: In any one cycle, a bank serves one read and one write. When the read and the write target the same entry, the read returns the value held before the write.
- R7: bank_rd_en[b] is high exactly when a granted read of a nonzero register maps to bank b. bank_wr_en[b] follows the same rule for granted writes.
- R8: A read of register 0 is always granted, returns zero and raises no bank enable. A write to register 0 is always granted, is discarded and raises no bank enable. Neither one blocks another requester from the bank that register 0 would otherwise share.
- R9: After reset, every entry reads as zero. Before any request arrives, all grants, all bank enables and all data lanes are low.
- R10: A write granted in cycle N can be seen by a read that is granted in cycle N+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | N_RD | Read request per requester |
| rd_addr | input | N_RD*7 | Register number per read requester, requester i at bits [7i+6:7i] |
| rd_grant | output | N_RD | Read grant per requester, same cycle; low with request high means stall |
| rd_data | output | N_RD*64 | Read data per requester, one cycle after the grant, lane i at bits [64i+63:64i] |
| wr_req | input | N_WR | Write request per requester |
| wr_addr | input | N_WR*7 | Register number per write requester |
| wr_data | input | N_WR*64 | Write data per write requester |
| wr_grant | output | N_WR | Write grant per requester, same cycle |
| bank_rd_en | output | 8 | Per-bank read enable, bit b for bank b |
| bank_wr_en | output | 8 | Per-bank write enable, bit b for bank b |

## Verification
Grants and bank enables are combinational, so they become valid in the same cycle as the request. The bench drives a request on the falling edge and samples these outputs shortly after, before the next rising edge. Read data passes through one bank register, so it is due one rising edge after the grant. The bench samples it on the following falling edge. A written value becomes readable only after the rising edge that commits it, so read-back checks are issued one cycle after the write at the earliest.

// File: rtl/rfb_pkg.sv
// Package: shared helpers for the low-bit banked register file.
// Assumes: callers pass counts of at least one.
package rfb_pkg;

    // Width of an index that selects one of n items (at least 1 bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rfb_arbiter.sv
// Module: rfb_arbiter
// What:    Fixed-priority bank arbiter for one access kind (reads or writes).
//          For each bank, the lowest-indexed requester whose register number
//          maps to that bank wins. Register 0 is granted outright and uses
//          no bank slot.
// Assumes: the bank index is the low BANK_BITS of the register number.
module rfb_arbiter
    import rfb_pkg::*;
#(
    parameter int N_REQ     = 4,
    parameter int ADDR_W    = 7,
    parameter int BANK_BITS = 3,
    localparam int N_BANK   = 1 << BANK_BITS,
    localparam int IDX_W    = idx_width(N_REQ)
) (
    input  logic [N_REQ-1:0]        req,
    input  logic [N_REQ*ADDR_W-1:0] addr,
    output logic [N_REQ-1:0]        grant,
    output logic [N_BANK-1:0]       bank_en,
    output logic [N_BANK*IDX_W-1:0] winner
);

    // Purpose: scan requesters from lowest index and claim free banks.
    always_comb begin
        grant   = '0;
        bank_en = '0;
        winner  = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req[i]) begin
                if (addr[i*ADDR_W +: ADDR_W] == '0) begin
                    grant[i] = 1'b1;
                end else if (!bank_en[addr[i*ADDR_W +: BANK_BITS]]) begin
                    bank_en[addr[i*ADDR_W +: BANK_BITS]] = 1'b1;
                    grant[i] = 1'b1;
                    winner[addr[i*ADDR_W +: BANK_BITS]*IDX_W +: IDX_W] = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/rfb_bank.sv
// Module: rfb_bank
// What:    One storage bank with one synchronous read and one write per cycle.
//          A read that hits the entry being written gets the old contents.
// Assumes: enables are low in cycles where the bank is not used, so the
//          read register holds its value and the array is untouched.
module rfb_bank #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 4,
    localparam int DEPTH = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Purpose: clear the array on reset and commit granted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_word] <= wr_data;
        end
    end

    // Purpose: register the addressed word for a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_word];
        end
    end

endmodule

// File: rtl/rfb_read_steer.sv
// Module: rfb_read_steer
// What:    Remembers, for each read requester, whether it got a bank read
//          and from which bank, then routes that bank's output to the
//          requester's lane one cycle later. The lane is zero otherwise.
// Assumes: the bank outputs are valid in the cycle after their enable.
module rfb_read_steer #(
    parameter int N_RD      = 4,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 7,
    parameter int BANK_BITS = 3,
    localparam int N_BANK   = 1 << BANK_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_RD-1:0]          rd_grant,
    input  logic [N_RD*ADDR_W-1:0]   rd_addr,
    input  logic [N_BANK*DATA_W-1:0] bank_q,
    output logic [N_RD*DATA_W-1:0]   rd_data
);

    logic [N_RD-1:0]                hit_q;
    logic [N_RD-1:0][BANK_BITS-1:0] sel_q;

    // Purpose: capture bank choice for every granted nonzero read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
            sel_q <= '0;
        end else begin
            for (int i = 0; i < N_RD; i++) begin
                hit_q[i] <= rd_grant[i] && (rd_addr[i*ADDR_W +: ADDR_W] != '0);
                sel_q[i] <= rd_addr[i*ADDR_W +: BANK_BITS];
            end
        end
    end

    // Purpose: route the chosen bank word to each lane, or zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_RD; i++) begin
            if (hit_q[i]) begin
                rd_data[i*DATA_W +: DATA_W] = bank_q[sel_q[i]*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/lowbit_bank_rf.sv
// Module: lowbit_bank_rf (top)
// What:    Register file spread over 2**BANK_BITS single-read single-write
//          banks by the low bits of the register number. Read and write
//          requests are arbitrated per bank with lowest-index priority.
//          Grants are returned in the same cycle and read data one cycle
//          later. Per-bank enables are raised only for granted accesses.
// Assumes: a requester that sees no grant holds and retries its request.
module lowbit_bank_rf
    import rfb_pkg::*;
#(
    parameter int N_RD      = 4,
    parameter int N_WR      = 2,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 7,
    parameter int BANK_BITS = 3,
    localparam int N_BANK   = 1 << BANK_BITS,
    localparam int WORD_W   = ADDR_W - BANK_BITS,
    localparam int RIDX_W   = idx_width(N_RD),
    localparam int WIDX_W   = idx_width(N_WR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_RD-1:0]        rd_req,
    input  logic [N_RD*ADDR_W-1:0] rd_addr,
    output logic [N_RD-1:0]        rd_grant,
    output logic [N_RD*DATA_W-1:0] rd_data,
    input  logic [N_WR-1:0]        wr_req,
    input  logic [N_WR*ADDR_W-1:0] wr_addr,
    input  logic [N_WR*DATA_W-1:0] wr_data,
    output logic [N_WR-1:0]        wr_grant,
    output logic [N_BANK-1:0]      bank_rd_en,
    output logic [N_BANK-1:0]      bank_wr_en
);

    logic [N_BANK*RIDX_W-1:0] rd_winner;
    logic [N_BANK*WIDX_W-1:0] wr_winner;
    logic [N_BANK*DATA_W-1:0] bank_q;

    rfb_arbiter #(.N_REQ(N_RD), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_rd_arb (
        .req     (rd_req),
        .addr    (rd_addr),
        .grant   (rd_grant),
        .bank_en (bank_rd_en),
        .winner  (rd_winner)
    );

    rfb_arbiter #(.N_REQ(N_WR), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_wr_arb (
        .req     (wr_req),
        .addr    (wr_addr),
        .grant   (wr_grant),
        .bank_en (bank_wr_en),
        .winner  (wr_winner)
    );

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic [RIDX_W-1:0] rsel;
        logic [WIDX_W-1:0] wsel;
        logic [WORD_W-1:0] rword;
        logic [WORD_W-1:0] wword;
        logic [DATA_W-1:0] wdat;

        // Purpose: select the winning requester's word address and data.
        always_comb begin
            rsel  = rd_winner[b*RIDX_W +: RIDX_W];
            wsel  = wr_winner[b*WIDX_W +: WIDX_W];
            rword = rd_addr[rsel*ADDR_W + BANK_BITS +: WORD_W];
            wword = wr_addr[wsel*ADDR_W + BANK_BITS +: WORD_W];
            wdat  = wr_data[wsel*DATA_W +: DATA_W];
        end

        rfb_bank #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (bank_rd_en[b]),
            .rd_word (rword),
            .rd_q    (bank_q[b*DATA_W +: DATA_W]),
            .wr_en   (bank_wr_en[b]),
            .wr_word (wword),
            .wr_data (wdat)
        );
    end

    rfb_read_steer #(
        .N_RD(N_RD), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)
    ) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_grant (rd_grant),
        .rd_addr  (rd_addr),
        .bank_q   (bank_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/rfb_checker.sv
// Module: rfb_checker
// What:    Port-level properties of lowbit_bank_rf, attached by bind.
// Assumes: the same parameter values as the bound instance.
module rfb_checker #(
    parameter int N_RD      = 4,
    parameter int N_WR      = 2,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 7,
    parameter int BANK_BITS = 3,
    localparam int N_BANK   = 1 << BANK_BITS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_RD-1:0]        rd_req,
    input logic [N_RD*ADDR_W-1:0] rd_addr,
    input logic [N_RD-1:0]        rd_grant,
    input logic [N_RD*DATA_W-1:0] rd_data,
    input logic [N_WR-1:0]        wr_req,
    input logic [N_WR*ADDR_W-1:0] wr_addr,
    input logic [N_WR-1:0]        wr_grant,
    input logic [N_BANK-1:0]      bank_rd_en,
    input logic [N_BANK-1:0]      bank_wr_en
);

    logic [N_BANK-1:0][N_RD-1:0] rd_slot;
    logic [N_BANK-1:0][N_WR-1:0] wr_slot;
    logic [N_RD-1:0]             rd_stall_ok;
    logic [N_WR-1:0]             wr_stall_ok;

    // Purpose: map granted reads to banks and justify every read stall.
    always_comb begin
        rd_slot     = '0;
        rd_stall_ok = '1;
        for (int i = 0; i < N_RD; i++) begin
            logic found;
            found = 1'b0;
            if (rd_grant[i] && (rd_addr[i*ADDR_W +: ADDR_W] != '0))
                rd_slot[rd_addr[i*ADDR_W +: BANK_BITS]][i] = 1'b1;
            for (int j = 0; j < i; j++) begin
                if (rd_grant[j] && (rd_addr[j*ADDR_W +: ADDR_W] != '0) &&
                    (rd_addr[j*ADDR_W +: BANK_BITS] == rd_addr[i*ADDR_W +: BANK_BITS]))
                    found = 1'b1;
            end
            if (rd_req[i] && !rd_grant[i] &&
                ((rd_addr[i*ADDR_W +: ADDR_W] == '0) || !found))
                rd_stall_ok[i] = 1'b0;
        end
    end

    // Purpose: map granted writes to banks and justify every write stall.
    always_comb begin
        wr_slot     = '0;
        wr_stall_ok = '1;
        for (int i = 0; i < N_WR; i++) begin
            logic found;
            found = 1'b0;
            if (wr_grant[i] && (wr_addr[i*ADDR_W +: ADDR_W] != '0))
                wr_slot[wr_addr[i*ADDR_W +: BANK_BITS]][i] = 1'b1;
            for (int j = 0; j < i; j++) begin
                if (wr_grant[j] && (wr_addr[j*ADDR_W +: ADDR_W] != '0) &&
                    (wr_addr[j*ADDR_W +: BANK_BITS] == wr_addr[i*ADDR_W +: BANK_BITS]))
                    found = 1'b1;
            end
            if (wr_req[i] && !wr_grant[i] &&
                ((wr_addr[i*ADDR_W +: ADDR_W] == '0) || !found))
                wr_stall_ok[i] = 1'b0;
        end
    end

    a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_grant & ~rd_req) == '0) && ((wr_grant & ~wr_req) == '0));

    a_r4_rd_stall_justified: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall_ok == '1);

    a_r5_wr_stall_justified: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall_ok == '1);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank_chk
        a_r6_one_read_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rd_slot[b]) <= 1);
        a_r6_one_write_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wr_slot[b]) <= 1);
        a_r7_rd_enable_match: assert property (@(posedge clk) disable iff (!rst_n)
            bank_rd_en[b] == (|rd_slot[b]));
        a_r7_wr_enable_match: assert property (@(posedge clk) disable iff (!rst_n)
            bank_wr_en[b] == (|wr_slot[b]));
    end

    for (genvar i = 0; i < N_RD; i++) begin : g_lane_chk
        a_r2_lane_zero_without_read: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_grant[i] && (rd_addr[i*ADDR_W +: ADDR_W] != '0))
            |=> (rd_data[i*DATA_W +: DATA_W] == '0));
        a_r8_zero_reg_granted: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[i] && (rd_addr[i*ADDR_W +: ADDR_W] == '0)) |-> rd_grant[i]);
    end

endmodule

bind lowbit_bank_rf rfb_checker #(
    .N_RD(N_RD), .N_WR(N_WR), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_grant   (rd_grant),
    .rd_data    (rd_data),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_grant   (wr_grant),
    .bank_rd_en (bank_rd_en),
    .bank_wr_en (bank_wr_en)
);

// File: tb/sim_lowbit_bank_rf.sv
// Bench: directed scenarios for lowbit_bank_rf. Inputs change on the
// falling edge. Grants and enables are sampled 1 ns later. Read data is
// sampled on the falling edge that follows the rising edge of the grant.
module sim_lowbit_bank_rf;

    localparam int NR = 4;
    localparam int NW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    rd_req;
    logic [NR*7-1:0]  rd_addr;
    logic [NR-1:0]    rd_grant;
    logic [NR*64-1:0] rd_data;
    logic [NW-1:0]    wr_req;
    logic [NW*7-1:0]  wr_addr;
    logic [NW*64-1:0] wr_data;
    logic [NW-1:0]    wr_grant;
    logic [7:0]       bank_rd_en;
    logic [7:0]       bank_wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lowbit_bank_rf u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_grant(wr_grant),
        .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle();
        rd_req = '0; rd_addr = '0; wr_req = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic set_rd(input int i, input logic [6:0] a);
        rd_req[i] = 1'b1; rd_addr[i*7 +: 7] = a;
    endtask

    task automatic set_wr(input int i, input logic [6:0] a, input logic [63:0] d);
        wr_req[i] = 1'b1; wr_addr[i*7 +: 7] = a; wr_data[i*64 +: 64] = d;
    endtask

    function automatic logic [63:0] lane(input int i);
        return rd_data[i*64 +: 64];
    endfunction

    // Wait for the commit edge, then move to the next falling edge.
    task automatic advance();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // Single read of one register on requester 0, checking the returned value.
    task automatic read_one(input string tag, input logic [6:0] a, input logic [63:0] exp);
        set_rd(0, a);
        #1;
        chk({tag, " grant"}, 64'(rd_grant), 64'h1);
        advance();
        chk({tag, " data"}, lane(0), exp);
    endtask

    task automatic t_reset();
        #1;
        chk("R9 rd_grant idle", 64'(rd_grant), 0);
        chk("R9 wr_grant idle", 64'(wr_grant), 0);
        chk("R9 enables idle", 64'({bank_rd_en, bank_wr_en}), 0);
        chk("R9 lanes zero", 64'(|rd_data), 0);
        read_one("R9 cleared r9", 7'd9, 64'h0);
    endtask

    task automatic t_spread();
        set_wr(0, 7'd1, 64'hA1); set_wr(1, 7'd2, 64'hB2);
        #1;
        chk("R1 two writes granted", 64'(wr_grant), 64'h3);
        chk("R7 write banks 1,2", 64'(bank_wr_en), 64'h06);
        advance();
        set_wr(0, 7'd11, 64'hC3); set_wr(1, 7'd20, 64'hD4);
        #1;
        chk("R7 write banks 3,4", 64'(bank_wr_en), 64'h18);
        advance();
        set_rd(0, 7'd1); set_rd(1, 7'd2); set_rd(2, 7'd11); set_rd(3, 7'd20);
        #1;
        chk("R1 four reads granted", 64'(rd_grant), 64'hF);
        chk("R7 read banks 1-4", 64'(bank_rd_en), 64'h1E);
        advance();
        chk("R10 r1 lane0", lane(0), 64'hA1);
        chk("R2 r2 lane1", lane(1), 64'hB2);
        chk("R1 r11 lane2", lane(2), 64'hC3);
        chk("R1 r20 lane3", lane(3), 64'hD4);
    endtask

    task automatic t_word();
        set_wr(0, 7'd3, 64'hE5);
        advance();
        read_one("R1 r3 word0 bank3", 7'd3, 64'hE5);
        read_one("R1 r11 word1 bank3", 7'd11, 64'hC3);
    endtask

    task automatic t_rd_conflict();
        set_rd(1, 7'd9); set_rd(2, 7'd1); set_rd(3, 7'd2);
        #1;
        chk("R4 bank1 lowest wins", 64'(rd_grant), 64'hA);
        chk("R7 read banks 1,2", 64'(bank_rd_en), 64'h06);
        advance();
        chk("R4 winner r9 data", lane(1), 64'h0);
        chk("R4 loser lane zero", lane(2), 64'h0);
        chk("R2 r2 lane3", lane(3), 64'hB2);
        chk("R2 idle lane0 zero", lane(0), 64'h0);
    endtask

    task automatic t_wr_conflict();
        set_wr(0, 7'd17, 64'hF6); set_wr(1, 7'd25, 64'h77);
        #1;
        chk("R5 bank1 write lowest wins", 64'(wr_grant), 64'h1);
        chk("R5 only bank1 write", 64'(bank_wr_en), 64'h02);
        advance();
        read_one("R5 winner stored r17", 7'd17, 64'hF6);
        read_one("R5 loser discarded r25", 7'd25, 64'h0);
    endtask

    task automatic t_same_entry();
        set_wr(0, 7'd2, 64'h88); set_rd(0, 7'd2);
        #1;
        chk("R6 read and write both granted", 64'({rd_grant, wr_grant}), 64'h5);
        chk("R6 bank2 both enables", 64'({bank_rd_en, bank_wr_en}), 64'h0404);
        advance();
        chk("R6 old value returned", lane(0), 64'hB2);
        read_one("R10 new value visible", 7'd2, 64'h88);
    endtask

    task automatic t_reg0();
        set_wr(0, 7'd0, 64'h99); set_wr(1, 7'd8, 64'h5A);
        set_rd(0, 7'd0); set_rd(1, 7'd16);
        #1;
        chk("R8 r0 write and r8 write granted", 64'(wr_grant), 64'h3);
        chk("R8 r0 write no bank", 64'(bank_wr_en), 64'h01);
        chk("R8 r0 read and r16 read granted", 64'(rd_grant), 64'h3);
        chk("R8 r0 read no bank", 64'(bank_rd_en), 64'h01);
        advance();
        chk("R8 r0 reads zero", lane(0), 64'h0);
        chk("R8 r16 shared bank0", lane(1), 64'h0);
        read_one("R8 r0 after write", 7'd0, 64'h0);
        read_one("R8 r8 stored", 7'd8, 64'h5A);
    endtask

    task automatic t_idle();
        #1;
        chk("R3 no grant without request", 64'({rd_grant, wr_grant}), 0);
        chk("R7 no enables idle", 64'({bank_rd_en, bank_wr_en}), 0);
        advance();
        chk("R2 lanes zero after idle", 64'(|rd_data), 0);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_spread();
        t_word();
        t_rd_conflict();
        t_wr_conflict();
        t_same_entry();
        t_reg0();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule